// File: doc/BRIEF.md
# 64-bit Integer Arithmetic-Logic Unit

The block is a purely combinational integer ALU for a 64-bit datapath. It takes two operands and a 4-bit operation code. It returns a 64-bit result, a signed-overflow flag and a zero-result flag, all in the same cycle. There are no registers inside it. The surrounding pipeline samples the outputs at whatever point its timing allows.

The operation set covers:
- four bitwise functions;
- addition and subtraction, each in a signed and an unsigned variant;
- signed and unsigned less-than comparison, returning 1 or 0;
- three shifts, which move operand B.

The shift count is six bits wide and arrives on two ports: a 5-bit low field and a separate extension bit that supplies bit 5. This lets the count reach 63.

Top module: `int_alu`

## Requirements
- R1: Codes 0, 1, 2 and 3 give A AND B, A OR B, A XOR B and NOT(A OR B) respectively, bit for bit.
- R2: Codes 4 (signed add) and 5 (unsigned add) both give A + B modulo 2^64.
- R3: Codes 6 (signed subtract) and 7 (unsigned subtract) both give A - B modulo 2^64.
- R4: ovf_o is 1 only for code 4 or code 6, and only when the true two's-complement sum or difference does not fit in 64 signed bits. ovf_o is 0 for codes 5 and 7 and for every other code.
- R5: Code 8 gives 1 when A < B as signed 64-bit numbers and 0 otherwise, zero-extended to 64 bits. The answer is correct even when A - B overflows.
- R6: Code 9 gives 1 when A < B as unsigned numbers and 0 otherwise, zero-extended.
- R7: Code 10 shifts B left by the count {shamt_hi_i, shamt_i} (bit 5 = shamt_hi_i) and fills with zeros.
- R8: Code 11 shifts B right logically by the same count and fills with zeros.
- R9: Code 12 shifts B right arithmetically by the same count and fills with B bit 63.
- R10: A shift count of 0 returns B unchanged for all three shifts. A count of 63 leaves at most one source bit in the result.
- R11: zero_o is 1 exactly when the 64-bit result is all zeros, for every code.
- R12: Codes 13, 14 and 15 give a zero result with ovf_o at 0, so zero_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B; also the value that is shifted |
| op_i | input | 4 | Operation code (0..12 valid) |
| shamt_i | input | 5 | Shift count bits 4..0 |
| shamt_hi_i | input | 1 | Shift count bit 5 |
| res_o | output | 64 | Result |
| ovf_o | output | 1 | Signed add/subtract overflow |
| zero_o | output | 1 | Result is all zeros |

## Verification
The overflow flag and the zero flag can both rise on the same vector. A signed add of 0x8000_0000_0000_0000 to itself wraps to zero while overflowing. A signed subtract of the most negative value from zero also overflows. The bench applies these vectors and checks both flags against a wide reference sum computed in the bench. Overflow also meets comparison: signed less-than with operand pairs whose difference overflows must still give the mathematically correct ordering, and the same pairs are replayed as unsigned operations to confirm that ovf_o stays low.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_NOR  = 4'd3,
    OP_ADD  = 4'd4,
    OP_ADDU = 4'd5,
    OP_SUB  = 4'd6,
    OP_SUBU = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_SLL  = 4'd10,
    OP_SRL  = 4'd11,
    OP_SRA  = 4'd12
  } alu_op_e;
endpackage

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o,
  output logic [W-1:0] nor_o
);
  always_comb begin
    and_o = a_i & b_i;
    or_o  = a_i | b_i;
    xor_o = a_i ^ b_i;
    nor_o = ~(a_i | b_i);
  end
endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  logic [W-1:0] b_x;
  logic [W:0]   full;

  always_comb begin
    b_x    = sub_i ? ~b_i : b_i;
    full   = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, sub_i};
    sum_o  = full[W-1:0];
    // same-sign inputs, different-sign output
    ovf_o  = (a_i[W-1] == b_x[W-1]) && (full[W-1] != a_i[W-1]);
    // sign corrected by overflow term
    lt_s_o = full[W-1] ^ ovf_o;
    // no carry out of A + ~B + 1 means borrow
    lt_u_o = ~full[W];
    if (sub_i) begin
      // R5
      slt_signed_chk: assert (lt_s_o == ($signed(a_i) < $signed(b_i)));
      // R6
      slt_unsigned_chk: assert (lt_u_o == (a_i < b_i));
    end
  end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int W  = 64,
  parameter int CW = 6
) (
  input  logic [W-1:0]  b_i,
  input  logic [CW-1:0] cnt_i,
  output logic [W-1:0]  sll_o,
  output logic [W-1:0]  srl_o,
  output logic [W-1:0]  sra_o
);
  logic [CW:0][W-1:0] l_st;
  logic [CW:0][W-1:0] r_st;
  logic [CW:0][W-1:0] a_st;

  assign l_st[0] = b_i;
  assign r_st[0] = b_i;
  assign a_st[0] = b_i;

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign l_st[k+1] = cnt_i[k] ? {l_st[k][W-1-S:0], {S{1'b0}}} : l_st[k];
    assign r_st[k+1] = cnt_i[k] ? {{S{1'b0}}, r_st[k][W-1:S]} : r_st[k];
    assign a_st[k+1] = cnt_i[k] ? {{S{b_i[W-1]}}, a_st[k][W-1:S]} : a_st[k];
  end

  assign sll_o = l_st[CW];
  assign srl_o = r_st[CW];
  assign sra_o = a_st[CW];

  always_comb begin
    if (cnt_i == '0) begin
      // R10
      zero_shift_chk: assert (sll_o == b_i && srl_o == b_i && sra_o == b_i);
    end
    // R9
    sra_fill_chk: assert (sra_o[W-1] == b_i[W-1]);
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 5
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [3:0]         op_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               shamt_hi_i,
  output logic [DATA_W-1:0]  res_o,
  output logic               ovf_o,
  output logic               zero_o
);
  localparam int CNT_W = SHAMT_W + 1;

  logic [DATA_W-1:0] and_w, or_w, xor_w, nor_w;
  logic [DATA_W-1:0] sum_w, sll_w, srl_w, sra_w;
  logic              as_ovf, lt_s, lt_u, sub_en;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] res;
  logic              ovf;

  assign sub_en = (op_i == OP_SUB) || (op_i == OP_SUBU) ||
                  (op_i == OP_SLT) || (op_i == OP_SLTU);
  assign cnt    = {shamt_hi_i, shamt_i};

  int_alu_logic #(.W(DATA_W)) u_logic (
    .a_i(a_i), .b_i(b_i),
    .and_o(and_w), .or_o(or_w), .xor_o(xor_w), .nor_o(nor_w)
  );

  int_alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(sub_en),
    .sum_o(sum_w), .ovf_o(as_ovf), .lt_s_o(lt_s), .lt_u_o(lt_u)
  );

  int_alu_shift #(.W(DATA_W), .CW(CNT_W)) u_shift (
    .b_i(b_i), .cnt_i(cnt),
    .sll_o(sll_w), .srl_o(srl_w), .sra_o(sra_w)
  );

  always_comb begin
    res = '0;
    ovf = 1'b0;
    case (op_i)
      OP_AND:  res = and_w;
      OP_OR:   res = or_w;
      OP_XOR:  res = xor_w;
      OP_NOR:  res = nor_w;
      OP_ADD:  begin res = sum_w; ovf = as_ovf; end
      OP_ADDU: res = sum_w;
      OP_SUB:  begin res = sum_w; ovf = as_ovf; end
      OP_SUBU: res = sum_w;
      OP_SLT:  res = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU: res = {{(DATA_W-1){1'b0}}, lt_u};
      OP_SLL:  res = sll_w;
      OP_SRL:  res = srl_w;
      OP_SRA:  res = sra_w;
      default: res = '0;
    endcase
    res_o  = res;
    ovf_o  = ovf;
    zero_o = ~|res;

    if (op_i > OP_SRA) begin
      // R12
      bad_op_chk: assert (res == '0 && !ovf);
    end
    if (op_i == OP_ADDU || op_i == OP_SUBU) begin
      // R4
      no_overflow_chk: assert (!ovf);
    end
    if (op_i == OP_SLT || op_i == OP_SLTU) begin
      // R5
      slt_width_chk: assert (res[DATA_W-1:1] == '0);
    end
  end
endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;
  typedef struct {
    logic [63:0] res;
    logic        ovf;
    logic        zero;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] a, b;
  logic [3:0]  op;
  logic [4:0]  shamt;
  logic        shamt_hi;
  logic [63:0] res;
  logic        ovf, zero;

  item_t exp_q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;

  always #4 clk = ~clk;

  int_alu u_int_alu (
    .a_i(a), .b_i(b), .op_i(op), .shamt_i(shamt), .shamt_hi_i(shamt_hi),
    .res_o(res), .ovf_o(ovf), .zero_o(zero)
  );

  function automatic item_t model(logic [3:0] o, logic [63:0] x, logic [63:0] y,
                                  logic [5:0] c, string tag);
    item_t it;
    logic signed [64:0] w;
    it.res = '0;
    it.ovf = 1'b0;
    it.tag = tag;
    case (o)
      4'd0:  it.res = x & y;
      4'd1:  it.res = x | y;
      4'd2:  it.res = x ^ y;
      4'd3:  it.res = ~(x | y);
      4'd4, 4'd5: it.res = x + y;
      4'd6, 4'd7: it.res = x - y;
      4'd8:  it.res = ($signed(x) < $signed(y)) ? 64'd1 : 64'd0;
      4'd9:  it.res = (x < y) ? 64'd1 : 64'd0;
      4'd10: it.res = y << c;
      4'd11: it.res = y >> c;
      4'd12: it.res = $signed(y) >>> c;
      default: it.res = '0;
    endcase
    if (o == 4'd4) begin
      w = $signed({x[63], x}) + $signed({y[63], y});
      it.ovf = w[64] != w[63];
    end else if (o == 4'd6) begin
      w = $signed({x[63], x}) - $signed({y[63], y});
      it.ovf = w[64] != w[63];
    end
    it.zero = (it.res == 64'd0);
    return it;
  endfunction

  task automatic drive(logic [3:0] o, logic [63:0] x, logic [63:0] y,
                       logic [5:0] c, string tag);
    @(posedge clk);
    #1;
    op = o; a = x; b = y; shamt = c[4:0]; shamt_hi = c[5];
    exp_q.push_back(model(o, x, y, c, tag));
  endtask

  // monitor: compare one item per cycle, mid-period
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && exp_q.size() > 0) begin
        item_t e;
        e = exp_q.pop_front();
        n_run++;
        if (res !== e.res || ovf !== e.ovf || zero !== e.zero) begin
          n_fail++;
          $display("FAIL %s res=%h exp=%h ovf=%b exp=%b zero=%b exp=%b",
                   e.tag, res, e.res, ovf, e.ovf, zero, e.zero);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    op = 4'd0; a = '0; b = '0; shamt = '0; shamt_hi = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: idle inputs give zero result, zero flag set
    drive(4'd0, 64'd0, 64'd0, 6'd0, "R11 reset idle");
    // R1 logic
    drive(4'd0, 64'hF0F0_1234_FFFF_0000, 64'hFF00_FF00_0F0F_1111, 6'd0, "R1 and");
    drive(4'd1, 64'hF0F0_1234_FFFF_0000, 64'h0F00_FF00_0F0F_1111, 6'd0, "R1 or");
    drive(4'd2, 64'hAAAA_5555_0000_FFFF, 64'hAAAA_AAAA_FFFF_FFFF, 6'd0, "R1 xor");
    drive(4'd3, 64'h0000_0000_0000_0001, 64'h0, 6'd0, "R1 nor");
    drive(4'd3, '1, 64'h0, 6'd0, "R1 R11 nor zero");
    // R2 add
    drive(4'd4, 64'd123456789, 64'd987654321, 6'd0, "R2 add");
    drive(4'd5, '1, 64'd1, 6'd0, "R2 R4 R11 addu wrap no ovf");
    drive(4'd4, MAXV, 64'd1, 6'd0, "R4 add pos ovf");
    drive(4'd4, MINV, MINV, 6'd0, "R4 R11 add ovf and zero");
    drive(4'd5, MAXV, 64'd1, 6'd0, "R4 addu no ovf");
    drive(4'd4, '1, '1, 6'd0, "R2 add neg no ovf");
    // R3 sub
    drive(4'd6, 64'd5, 64'd9, 6'd0, "R3 sub neg");
    drive(4'd7, 64'd0, 64'd1, 6'd0, "R3 subu wrap");
    drive(4'd6, 64'd0, MINV, 6'd0, "R4 sub ovf");
    drive(4'd6, MINV, 64'd1, 6'd0, "R4 sub neg ovf");
    drive(4'd7, MINV, 64'd1, 6'd0, "R4 subu no ovf");
    drive(4'd6, 64'd77, 64'd77, 6'd0, "R3 R11 sub zero");
    // R5 / R6 compare, including overflowing differences
    drive(4'd8, '1, 64'd1, 6'd0, "R5 slt -1<1");
    drive(4'd9, '1, 64'd1, 6'd0, "R6 sltu max>1");
    drive(4'd8, MINV, MAXV, 6'd0, "R5 slt ovf case true");
    drive(4'd8, MAXV, MINV, 6'd0, "R5 slt ovf case false");
    drive(4'd9, MINV, MAXV, 6'd0, "R6 sltu");
    drive(4'd8, 64'd3, 64'd3, 6'd0, "R5 slt equal");
    drive(4'd9, 64'd2, 64'd3, 6'd0, "R6 sltu true");
    // R7-R10 shifts
    drive(4'd10, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 6'd4, "R7 sll 4");
    drive(4'd10, 64'd0, 64'h0000_0000_0000_0003, 6'd63, "R7 R10 sll 63");
    drive(4'd10, 64'd0, 64'hDEAD_BEEF_0000_0001, 6'd33, "R7 sll hi bit");
    drive(4'd11, 64'd0, MINV | 64'h1, 6'd63, "R8 R10 srl 63");
    drive(4'd11, 64'd0, 64'hF000_0000_0000_0000, 6'd36, "R8 srl 36");
    drive(4'd12, 64'd0, 64'hF000_0000_0000_0000, 6'd36, "R9 sra neg 36");
    drive(4'd12, 64'd0, 64'h7000_0000_0000_0000, 6'd60, "R9 sra pos 60");
    drive(4'd12, 64'd0, MINV, 6'd63, "R9 R10 sra 63");
    drive(4'd10, 64'd0, 64'hCAFE_F00D_1234_5678, 6'd0, "R10 sll 0");
    drive(4'd11, 64'd0, 64'hCAFE_F00D_1234_5678, 6'd0, "R10 srl 0");
    drive(4'd12, 64'd0, 64'hCAFE_F00D_1234_5678, 6'd0, "R10 sra 0");
    // R12 unused codes
    for (int k = 13; k < 16; k++) begin
      drive(4'(k), MAXV, 64'd1, 6'd5, "R12 unused code");
    end
    // walking operand patterns through every valid code
    for (int k = 0; k < 13; k++) begin
      drive(4'(k), 64'h8000_0001_7FFF_FFFE, 64'hFFFF_0000_8000_0001, 6'(k * 5), "R1 R2 R3 sweep");
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule